// File: doc/BRIEF.md
# Scanline Counter with Raster Timing Outputs

This block counts the video lines of a 256-line raster. A CPU can read the count as a byte. The block also produces two timing lines that drive the interrupt inputs of a parallel-interface device. The count advances once per line strobe, which is derived from the pixel clock. A frame-start pulse returns the count to zero, and the count also wraps from 255 back to 0 on its own.

The CPU sees the count with its two lowest bits forced to zero, so the value it reads changes once every four lines. An address decoder outside the block asserts a page-hit signal for every address in the counter's 256-byte page. Any read in that page therefore returns the same value. The read value is captured on the clock edge of the bus read, which keeps it steady for the rest of the bus cycle.

The first timing line is a square wave taken from one bit of the count (bit 5 by default), so its period is 64 lines. The second line marks the bottom of the frame: it is high on lines 240 to 255 and low on every other line. Sync generation and memory refresh belong to other blocks.

Top module: `scanline_timer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the count and `rd_data` clear to 0 and both `tick_wave` and `bottom_zone` go low.
- R2: A clock edge with `line_stb` high and `frame_start` low raises the count by exactly 1. An edge with both strobes low leaves the count unchanged.
- R3: The count wraps from 255 to 0 on a line strobe.
- R4: An edge with `frame_start` high sets the count to 0, whether or not `line_stb` is also high.
- R5: An edge with both `rd_stb` and `page_hit` high loads `rd_data` with the count. Bits 7 to 2 of `rd_data` equal bits 7 to 2 of the count, and bits 1 and 0 are always 0.
- R6: `rd_data` keeps its value on any edge where `rd_stb` or `page_hit` is low.
- R7: A read on the same edge as a line strobe or a frame start captures the count as it was before that edge.
- R8: `bottom_zone` is high exactly while the count is 240 through 255.
- R9: `tick_wave` equals bit 5 of the count, so it toggles every 32 lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| line_stb | input | 1 | One-cycle pulse at each new line |
| frame_start | input | 1 | One-cycle pulse at the first line of a frame |
| rd_stb | input | 1 | Bus read strobe |
| page_hit | input | 1 | High when the read address falls in the counter's page |
| rd_data | output | 8 | Last captured count, with bits 1 and 0 forced to zero |
| tick_wave | output | 1 | Square wave from count bit 5 |
| bottom_zone | output | 1 | High on lines 240 to 255 |

## Verification
A bus read can arrive on the same edge as a line strobe or a frame-start pulse. The captured byte must then hold the count from before that edge, not the updated one. The bench makes these collisions happen on purpose. It reads on every edge of a long run of line strobes, including the edge that wraps the count from 255 to 0 and an edge where a frame start and a line strobe arrive together. It also runs a long random mix of all four inputs. A behavioural model is updated read-first on each edge and compared with the outputs every cycle, so a design that captures the updated count fails on the first collision.

// File: rtl/scan_pkg.sv
package scan_pkg;

   // Timing marks derived from the current line number.
   typedef struct packed {
      logic wave;
      logic bottom;
   } scan_marks_t;

   // True when v is a positive power of two.
   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   // Mask that clears the lowest `hide` bits of a `width`-bit word.
   function automatic longint unsigned vis_mask(input int width, input int hide);
      longint unsigned all_ones;
      all_ones = (longint'(1) << width) - 1;
      return all_ones & ~((longint'(1) << hide) - 1);
   endfunction

endpackage

// File: rtl/scan_line_count.sv
module scan_line_count #(
   parameter int LINE_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_stb,
   input  logic              frame_start,
   output logic [LINE_W-1:0] line_q
);

   localparam logic [LINE_W-1:0] ONE = LINE_W'(1);

   // Frame start outranks the line strobe; the add wraps naturally.
   always_ff @(posedge clk) begin
      if (rst)
         line_q <= '0;
      else if (frame_start)
         line_q <= '0;
      else if (line_stb)
         line_q <= line_q + ONE;
   end

endmodule

// File: rtl/scan_zone_decode.sv
module scan_zone_decode
   import scan_pkg::*;
#(
   parameter int LINE_W       = 8,
   parameter int BOTTOM_FIRST = 240,
   parameter int WAVE_BIT     = 5
) (
   input  logic [LINE_W-1:0] line_q,
   output scan_marks_t       marks
);

   localparam int  SPAN    = (1 << LINE_W) - BOTTOM_FIRST;
   localparam bit  ALIGNED = is_pow2(SPAN);

   logic bottom_hit;

   generate
      if (ALIGNED) begin : g_aligned
         // Zone runs to the top of the range: the upper bits must all be one.
         localparam logic [LINE_W-1:0] LOW_ONES = LINE_W'(SPAN - 1);
         assign bottom_hit = &(line_q | LOW_ONES);
      end else begin : g_compare
         localparam logic [LINE_W-1:0] ZONE_LO = LINE_W'(BOTTOM_FIRST);
         assign bottom_hit = (line_q >= ZONE_LO);
      end
   endgenerate

   assign marks.bottom = bottom_hit;
   assign marks.wave   = line_q[WAVE_BIT];

endmodule

// File: rtl/scan_read_port.sv
module scan_read_port #(
   parameter int LINE_W    = 8,
   parameter int HIDE_LSBS = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rd_stb,
   input  logic              page_hit,
   input  logic [LINE_W-1:0] line_q,
   output logic [LINE_W-1:0] rd_q
);

   localparam logic [LINE_W-1:0] MASK =
      LINE_W'(scan_pkg::vis_mask(LINE_W, HIDE_LSBS));

   logic take;
   assign take = rd_stb & page_hit;

   // Captures the pre-edge count; holds between reads.
   always_ff @(posedge clk) begin
      if (rst)
         rd_q <= '0;
      else if (take)
         rd_q <= line_q & MASK;
   end

endmodule

// File: rtl/scanline_timer.sv
module scanline_timer #(
   parameter int LINE_W       = 8,
   parameter int HIDE_LSBS    = 2,
   parameter int BOTTOM_FIRST = 240,
   parameter int WAVE_BIT     = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              line_stb,
   input  logic              frame_start,
   input  logic              rd_stb,
   input  logic              page_hit,
   output logic [LINE_W-1:0] rd_data,
   output logic              tick_wave,
   output logic              bottom_zone
);

   generate
      if (LINE_W < 2 || LINE_W > 30) begin : g_bad_width
         $error("scanline_timer: LINE_W out of range");
      end
      if (HIDE_LSBS < 0 || HIDE_LSBS >= LINE_W) begin : g_bad_hide
         $error("scanline_timer: HIDE_LSBS must be below LINE_W");
      end
      if (WAVE_BIT < 0 || WAVE_BIT >= LINE_W) begin : g_bad_wave
         $error("scanline_timer: WAVE_BIT must index the count");
      end
      if (BOTTOM_FIRST <= 0 || BOTTOM_FIRST >= (1 << LINE_W)) begin : g_bad_zone
         $error("scanline_timer: BOTTOM_FIRST must lie inside the count range");
      end
   endgenerate

   logic [LINE_W-1:0]     line_q;
   scan_pkg::scan_marks_t marks;

   scan_line_count #(
      .LINE_W(LINE_W)
   ) u_count (
      .clk        (clk),
      .rst        (rst),
      .line_stb   (line_stb),
      .frame_start(frame_start),
      .line_q     (line_q)
   );

   scan_zone_decode #(
      .LINE_W      (LINE_W),
      .BOTTOM_FIRST(BOTTOM_FIRST),
      .WAVE_BIT    (WAVE_BIT)
   ) u_zone (
      .line_q(line_q),
      .marks (marks)
   );

   scan_read_port #(
      .LINE_W   (LINE_W),
      .HIDE_LSBS(HIDE_LSBS)
   ) u_read (
      .clk     (clk),
      .rst     (rst),
      .rd_stb  (rd_stb),
      .page_hit(page_hit),
      .line_q  (line_q),
      .rd_q    (rd_data)
   );

   assign tick_wave   = marks.wave;
   assign bottom_zone = marks.bottom;

endmodule

// File: rtl/scanline_timer_chk.sv
module scanline_timer_chk #(
   parameter int LINE_W       = 8,
   parameter int HIDE_LSBS    = 2,
   parameter int BOTTOM_FIRST = 240,
   parameter int WAVE_BIT     = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              line_stb,
   input logic              frame_start,
   input logic              rd_stb,
   input logic              page_hit,
   input logic [LINE_W-1:0] rd_data,
   input logic              tick_wave,
   input logic              bottom_zone,
   input logic [LINE_W-1:0] line_q
);

   localparam logic [LINE_W-1:0] MASK    = LINE_W'(scan_pkg::vis_mask(LINE_W, HIDE_LSBS));
   localparam logic [LINE_W-1:0] ZONE_LO = LINE_W'(BOTTOM_FIRST);
   localparam logic [LINE_W-1:0] TOP     = '1;

   logic rst_d = 1'b0;
   always_ff @(posedge clk) rst_d <= rst;

   // R1: one edge after a reset edge, everything sits at its cleared value
   always @(posedge clk) begin
      if (rst_d) begin
         p_reset_r1: assert (line_q == '0 && rd_data == '0 && !tick_wave && !bottom_zone)
            else $error("reset state wrong");
      end
   end

   p_step_r2: assert property (@(posedge clk) disable iff (rst)
      (line_stb && !frame_start) |=> line_q == LINE_W'($past(line_q) + 1'b1));

   p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      (!line_stb && !frame_start) |=> $stable(line_q));

   p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
      (line_q == TOP && line_stb && !frame_start) |=> line_q == '0);

   p_frame_r4: assert property (@(posedge clk) disable iff (rst)
      frame_start |=> line_q == '0);

   p_capture_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_stb && page_hit) |=> rd_data == ($past(line_q) & MASK));

   p_low_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_data & ~MASK) == '0);

   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      !(rd_stb && page_hit) |=> $stable(rd_data));

   p_bottom_r8: assert property (@(posedge clk) disable iff (rst)
      bottom_zone == (line_q >= ZONE_LO));

   p_wave_r9: assert property (@(posedge clk) disable iff (rst)
      tick_wave == line_q[WAVE_BIT]);

endmodule

bind scanline_timer scanline_timer_chk #(
   .LINE_W      (LINE_W),
   .HIDE_LSBS   (HIDE_LSBS),
   .BOTTOM_FIRST(BOTTOM_FIRST),
   .WAVE_BIT    (WAVE_BIT)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .line_stb   (line_stb),
   .frame_start(frame_start),
   .rd_stb     (rd_stb),
   .page_hit   (page_hit),
   .rd_data    (rd_data),
   .tick_wave  (tick_wave),
   .bottom_zone(bottom_zone),
   .line_q     (line_q)
);

// File: tb/scanline_timer_test.sv
`timescale 1ns/1ps
module scanline_timer_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       line_stb = 1'b0;
   logic       frame_start = 1'b0;
   logic       rd_stb = 1'b0;
   logic       page_hit = 1'b0;
   logic [7:0] rd_data;
   logic       tick_wave;
   logic       bottom_zone;

   int checks = 0;
   int errors = 0;

   // behavioural reference
   int m_cnt = 0;
   int m_rd  = 0;

   always #4 clk = ~clk;   // 125 MHz

   scanline_timer uut (
      .clk        (clk),
      .rst        (rst),
      .line_stb   (line_stb),
      .frame_start(frame_start),
      .rd_stb     (rd_stb),
      .page_hit   (page_hit),
      .rd_data    (rd_data),
      .tick_wave  (tick_wave),
      .bottom_zone(bottom_zone)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all(input string req);
      check(req, int'(rd_data), m_rd);
      check("R8 bottom_zone", int'(bottom_zone), (m_cnt >= 240) ? 1 : 0);
      check("R9 tick_wave", int'(tick_wave), (m_cnt >> 5) & 1);
   endtask

   // Drive one cycle, update the model read-first, compare at the falling edge.
   task automatic step(input bit ls, input bit fs, input bit rd, input bit hit,
                       input string req);
      line_stb    = ls;
      frame_start = fs;
      rd_stb      = rd;
      page_hit    = hit;
      @(posedge clk);
      if (rd && hit) m_rd = m_cnt & 8'hFC;
      if (fs) m_cnt = 0;
      else if (ls) m_cnt = (m_cnt + 1) % 256;
      @(negedge clk);
      compare_all(req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 rd_data", int'(rd_data), 0);
      check("R1 tick_wave", int'(tick_wave), 0);
      check("R1 bottom_zone", int'(bottom_zone), 0);
      rst = 1'b0;
      m_cnt = 0;
      m_rd  = 0;

      // R2: increments with idle gaps, read every cycle
      for (int i = 0; i < 12; i++) begin
         step(1, 0, 1, 1, "R2 count");
         step(0, 0, 1, 1, "R2 idle");
      end

      // R5: reads at counts with non-zero low bits
      for (int i = 0; i < 7; i++) begin
         step(1, 0, 0, 0, "R5 advance");
         step(0, 0, 1, 1, "R5 masked");
      end

      // R6: read strobe without page hit, page hit without strobe
      step(1, 0, 1, 0, "R6 no hit");
      step(1, 0, 0, 1, "R6 no strobe");
      step(1, 1, 1, 0, "R6 frame no hit");
      for (int i = 0; i < 9; i++) step(1, 0, 0, 0, "R6 advance");
      step(0, 0, 1, 1, "R6 read back");

      // R7: read collides with the line strobe
      for (int i = 0; i < 6; i++) step(1, 0, 1, 1, "R7 collide");
      step(0, 0, 1, 1, "R7 after");

      // R3, R8, R9: full sweep with reads, crossing 239->240 and 255->0
      for (int i = 0; i < 300; i++) step(1, 0, 1, 1, "R3 sweep");

      // R4: frame start together with line strobe and read (R7 too)
      for (int i = 0; i < 50; i++) step(1, 0, 0, 0, "R4 advance");
      step(1, 1, 1, 1, "R4 frame+read");
      step(0, 0, 1, 1, "R4 after frame");
      step(0, 1, 0, 0, "R4 lone frame");
      step(1, 0, 1, 1, "R4 restart");

      // Random mix of all inputs
      for (int i = 0; i < 3000; i++) begin
         step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 199) == 0),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), "R2 random");
      end

      // R1: reset mid-frame
      for (int i = 0; i < 20; i++) step(1, 0, 1, 1, "R2 pre-reset");
      rst = 1'b1;
      @(posedge clk);
      m_cnt = 0;
      m_rd  = 0;
      @(negedge clk);
      compare_all("R1 mid-frame reset");
      rst = 1'b0;
      step(0, 0, 1, 1, "R1 read after reset");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule